// File: doc/BRIEF.md
# Blank-Gated Video Memory Shift Clock Controller

This block produces the serial shift clock for a video memory and stops and restarts that clock, without glitches, under a blanking signal. Every clock in the block is an enable pulse taken from one fast reference clock. The shift clock itself is a level that this block generates by counting reference cycles. Each half period lasts `SHIFT_HALF` reference cycles.

There are two active-low blank inputs. The primary-port blank is captured on the rising-edge enable of its own port clock. The system blank is captured on the falling-edge enable of the video clock. A select bit picks which captured sample becomes the internal blank. The shift clock behaves as follows:
- When the internal blank turns active during a high phase, that phase runs to its full length and the clock then holds low.
- The clock restarts only when the internal blank is seen inactive again.
- A pixel-latch strobe follows the shift clock one group behind: the first rising edge after a restart only presents data, and every later rising edge also latches the group before it.

A delay line of selectable depth carries the internal blank, so that the blank reaching the output stays lined up with the pixel data.

Top module: `blank_shift_clock`

## Requirements
- R1: When `srcSel` is 1, the internal blank is the captured `portBlankN`. When it is 0, the internal blank is the captured `sysBlankN`.
- R2: `portBlankN` is captured only in cycles with `portClkRiseEn` high, and `sysBlankN` only in cycles with `vidClkFallEn` high. In all other cycles the captured value is held. A capture takes effect on the internal blank from the next cycle.
- R3: Both blanks are active low. During reset and in the first cycle after it, `shiftClk` is 0, `latchStrobe` is 0 and `alignedBlankN` is 0 (blank active).
- R4: Every high phase of `shiftClk` lasts exactly `SHIFT_HALF` cycles and is never cut short. While the clock runs, every low phase also lasts `SHIFT_HALF` cycles.
- R5: A high phase that ends while the internal blank is active leaves `shiftClk` low. While the internal blank is active and `shiftClk` is low, `shiftClk` stays low.
- R6: Once stopped, `shiftClk` rises in the cycle after the first cycle in which the internal blank is inactive.
- R7: `latchStrobe` is a one-cycle pulse in the cycle in which `shiftClk` rises, on every rising edge except the first one after a restart. Each run therefore has exactly one latch fewer than it has rising edges.
- R8: `alignedBlankN` equals the internal blank delayed by `pipeDepth` cycles. A `pipeDepth` of 0 acts as 1, and a value above `MAX_DEPTH` acts as `MAX_DEPTH`.
- R9: R4 to R7 hold whether the video clock period is shorter than, equal to, or longer than the shift clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| portClkRiseEn | input | 1 | Rising-edge enable of the primary port clock |
| vidClkFallEn | input | 1 | Falling-edge enable of the video clock |
| portBlankN | input | 1 | Primary-port blank, active low |
| sysBlankN | input | 1 | System blank, active low |
| srcSel | input | 1 | Blank source select, 1 = primary port |
| pipeDepth | input | DEPTH_W | Blank delay in cycles, 1..MAX_DEPTH |
| shiftClk | output | 1 | Video memory shift clock level |
| latchStrobe | output | 1 | Pixel-latch strobe, one cycle wide |
| alignedBlankN | output | 1 | Delayed internal blank, active low |

## Verification
The two blank inputs carry different toggle patterns with irregular segment lengths. This way, a wrong source select or a wrong capture edge shows up as a shifted shift clock. The video clock divider is swept over values below, equal to and above the shift clock period. This separates a correct capture edge from one taken on every cycle or on the wrong phase. The pipeline depth is swept from 0 to 9, covering both clamp limits. A cycle-by-cycle reference model compares all three outputs, and separate counters check the width of each high pulse and the number of latches in each run. Together they tell a truncated pulse apart from a missing or surplus latch.

// File: rtl/shiftclk_pkg.sv
package shiftclk_pkg;
  typedef enum logic [1:0] {
    ST_STOP = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } gateState_t;

  typedef struct packed {
    logic goHigh;
    logic goLow;
    logic latch;
  } sclkStrobe_t;
endpackage

// File: rtl/sclk_gate_ctrl.sv
module sclk_gate_ctrl
  import shiftclk_pkg::*;
#(
  parameter int SHIFT_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        intBlankN,
  output sclkStrobe_t strobe
);
  localparam int CNT_W = $clog2(SHIFT_HALF + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_HALF - 1);

  gateState_t       state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    strobe    = '0;
    unique case (state)
      ST_STOP: begin
        if (intBlankN) begin
          strobe.goHigh = 1'b1;  // first edge after restart: no latch
          nextState     = ST_HIGH;
          nextCnt       = '0;
        end
      end
      ST_HIGH: begin
        if (cnt == LAST) begin
          strobe.goLow = 1'b1;
          nextCnt      = '0;
          nextState    = intBlankN ? ST_LOW : ST_STOP;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_LOW: begin
        if (!intBlankN) begin
          nextState = ST_STOP;
          nextCnt   = '0;
        end else if (cnt == LAST) begin
          strobe.goHigh = 1'b1;
          strobe.latch  = 1'b1;
          nextState     = ST_HIGH;
          nextCnt       = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      default: begin
        nextState = ST_STOP;
        nextCnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_STOP;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end
endmodule

// File: rtl/sclk_datapath.sv
module sclk_datapath
  import shiftclk_pkg::*;
#(
  parameter int MAX_DEPTH = 8,
  parameter int DEPTH_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               portClkRiseEn,
  input  logic               vidClkFallEn,
  input  logic               portBlankN,
  input  logic               sysBlankN,
  input  logic               srcSel,
  input  logic [DEPTH_W-1:0] pipeDepth,
  input  sclkStrobe_t        strobe,
  output logic               intBlankN,
  output logic               shiftClk,
  output logic               latchStrobe,
  output logic               alignedBlankN
);
  localparam int IDX_W = $clog2(MAX_DEPTH);

  logic                 portSample, sysSample;
  logic [MAX_DEPTH-1:0] blankPipe;
  logic [DEPTH_W-1:0]   depthMinus;
  logic [IDX_W-1:0]     tapIdx;

  // each source captured on its own clock-edge enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      portSample <= 1'b0;
      sysSample  <= 1'b0;
    end else begin
      if (portClkRiseEn) portSample <= portBlankN;
      if (vidClkFallEn)  sysSample  <= sysBlankN;
    end
  end

  assign intBlankN = srcSel ? portSample : sysSample;

  always_ff @(posedge clk) begin
    if (!rstN) blankPipe <= '0;
    else       blankPipe <= {blankPipe[MAX_DEPTH-2:0], intBlankN};
  end

  assign depthMinus = pipeDepth - DEPTH_W'(1);

  always_comb begin
    if (pipeDepth == '0)
      tapIdx = '0;
    else if (pipeDepth > DEPTH_W'(MAX_DEPTH))
      tapIdx = IDX_W'(MAX_DEPTH - 1);
    else
      tapIdx = IDX_W'(depthMinus);
  end

  assign alignedBlankN = blankPipe[tapIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftClk    <= 1'b0;
      latchStrobe <= 1'b0;
    end else begin
      if (strobe.goHigh)     shiftClk <= 1'b1;
      else if (strobe.goLow) shiftClk <= 1'b0;
      latchStrobe <= strobe.goHigh & strobe.latch;
    end
  end
endmodule

// File: rtl/blank_shift_clock.sv
module blank_shift_clock
  import shiftclk_pkg::*;
#(
  parameter int SHIFT_HALF = 2,
  parameter int MAX_DEPTH  = 8,
  parameter int DEPTH_W    = $clog2(MAX_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               portClkRiseEn,
  input  logic               vidClkFallEn,
  input  logic               portBlankN,
  input  logic               sysBlankN,
  input  logic               srcSel,
  input  logic [DEPTH_W-1:0] pipeDepth,
  output logic               shiftClk,
  output logic               latchStrobe,
  output logic               alignedBlankN
);
  sclkStrobe_t strobe;
  logic        intBlankN;

  sclk_gate_ctrl #(.SHIFT_HALF(SHIFT_HALF)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .intBlankN(intBlankN),
    .strobe   (strobe)
  );

  sclk_datapath #(.MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .portClkRiseEn(portClkRiseEn),
    .vidClkFallEn (vidClkFallEn),
    .portBlankN   (portBlankN),
    .sysBlankN    (sysBlankN),
    .srcSel       (srcSel),
    .pipeDepth    (pipeDepth),
    .strobe       (strobe),
    .intBlankN    (intBlankN),
    .shiftClk     (shiftClk),
    .latchStrobe  (latchStrobe),
    .alignedBlankN(alignedBlankN)
  );
endmodule

// File: rtl/blank_shift_clock_chk.sv
module blank_shift_clock_chk #(
  parameter int SHIFT_HALF = 2
) (
  input logic clk,
  input logic rstN,
  input logic portClkRiseEn,
  input logic portBlankN,
  input logic srcSel,
  input logic intBlankN,
  input logic shiftClk,
  input logic latchStrobe,
  input logic alignedBlankN,
  input logic pipeDepthIsOne
);
  int hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN)         hiCnt <= 0;
    else if (shiftClk) hiCnt <= hiCnt + 1;
    else               hiCnt <= 0;
  end

  AST_HIGH_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftClk) |-> (hiCnt == SHIFT_HALF)); // R4

  AST_HOLD_LOW_IN_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftClk && !intBlankN) |=> !shiftClk); // R5

  AST_LATCH_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |-> $rose(shiftClk)); // R7

  AST_PORT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (portClkRiseEn && srcSel) |=> (!srcSel || (intBlankN == $past(portBlankN)))); // R1

  AST_MIN_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    pipeDepthIsOne |-> (alignedBlankN == $past(intBlankN))); // R8
endmodule

bind blank_shift_clock blank_shift_clock_chk #(.SHIFT_HALF(SHIFT_HALF)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .portClkRiseEn (portClkRiseEn),
  .portBlankN    (portBlankN),
  .srcSel        (srcSel),
  .intBlankN     (intBlankN),
  .shiftClk      (shiftClk),
  .latchStrobe   (latchStrobe),
  .alignedBlankN (alignedBlankN),
  .pipeDepthIsOne(pipeDepth == DEPTH_W'(1))
);

// File: tb/test_blank_shift_clock.sv
module test_blank_shift_clock;
  localparam int HALF   = 2;
  localparam int MAXD   = 8;
  localparam int DW     = 4;
  localparam int PORT_DIV = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portClkRiseEn = 1'b0, vidClkFallEn = 1'b0;
  logic portBlankN = 1'b0, sysBlankN = 1'b0, srcSel = 1'b0;
  logic [DW-1:0] pipeDepth = DW'(1);
  logic shiftClk, latchStrobe, alignedBlankN;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  blank_shift_clock #(.SHIFT_HALF(HALF), .MAX_DEPTH(MAXD), .DEPTH_W(DW)) i_blank_shift_clock (
    .clk(clk), .rstN(rstN), .portClkRiseEn(portClkRiseEn), .vidClkFallEn(vidClkFallEn),
    .portBlankN(portBlankN), .sysBlankN(sysBlankN), .srcSel(srcSel), .pipeDepth(pipeDepth),
    .shiftClk(shiftClk), .latchStrobe(latchStrobe), .alignedBlankN(alignedBlankN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  bit mPort, mSys, mClk, mLatch, mRun;
  int mPhase;
  bit [MAXD-1:0] mHist;
  bit modelOn = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPort = 0; mSys = 0; mClk = 0; mLatch = 0; mRun = 0; mPhase = 0; mHist = '0;
    end else begin
      bit ib;
      ib = srcSel ? mPort : mSys;            // R1
      mLatch = 0;
      if (!mRun) begin
        if (ib) begin mRun = 1; mClk = 1; mPhase = 0; end   // R6
      end else if (mClk) begin
        mPhase++;
        if (mPhase == HALF) begin              // R4
          mClk = 0; mPhase = 0;
          if (!ib) mRun = 0;                   // R5
        end
      end else if (!ib) begin
        mRun = 0; mPhase = 0;                  // R5
      end else begin
        mPhase++;
        if (mPhase == HALF) begin mClk = 1; mLatch = 1; mPhase = 0; end // R7
      end
      mHist = {mHist[MAXD-2:0], ib};
      if (portClkRiseEn) mPort = portBlankN;   // R2
      if (vidClkFallEn)  mSys  = sysBlankN;
    end
  end

  function automatic int effDepth(input logic [DW-1:0] d);
    if (d == 0) return 1;
    if (d > MAXD) return MAXD;
    return int'(d);
  endfunction

  // output comparison away from the active edge
  bit prevClk = 0;
  int hiWidth = 0, runRises = 0, runLatches = 0;
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      check(shiftClk == mClk, "R4/R5/R6 shiftClk", shiftClk, mClk);
      check(latchStrobe == mLatch, "R7 latchStrobe", latchStrobe, mLatch);
      check(alignedBlankN == mHist[effDepth(pipeDepth)-1], "R8 alignedBlankN",
            alignedBlankN, mHist[effDepth(pipeDepth)-1]);
      if (shiftClk) hiWidth++;
      if (!shiftClk && prevClk) begin
        check(hiWidth == HALF, "R4 high width", hiWidth, HALF);
        hiWidth = 0;
      end
      if (shiftClk && !prevClk) begin
        if (!latchStrobe) begin
          if (runRises > 0)
            check(runLatches == runRises - 1, "R7 latches per run", runLatches, runRises - 1);
          runRises = 0; runLatches = 0;
        end
        runRises++;
      end
      if (latchStrobe) runLatches++;
      prevClk = shiftClk;
    end
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int vdivs[3] = '{2, 4, 8};
    repeat (3) @(negedge clk);
    check(shiftClk == 0, "R3 reset shiftClk", shiftClk, 0);
    check(latchStrobe == 0, "R3 reset latchStrobe", latchStrobe, 0);
    check(alignedBlankN == 0, "R3 reset alignedBlankN", alignedBlankN, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(shiftClk == 0 && alignedBlankN == 0, "R3 first cycle after reset",
          {shiftClk, alignedBlankN}, 0);
    modelOn = 1'b1;
    for (int v = 0; v < 3; v++) begin          // R9: shorter, equal, longer
      for (int s = 0; s < 2; s++) begin
        for (int d = 0; d < 10; d++) begin
          int cfg = v * 20 + s * 10 + d;
          int sysSeg = 0, portSeg = 0, sysLeft = 5, portLeft = 9;
          srcSel = s[0];
          pipeDepth = DW'(d);
          for (int c = 0; c < 240; c++) begin
            vidClkFallEn  = ((c % vdivs[v]) == vdivs[v] - 1);
            portClkRiseEn = ((c % PORT_DIV) == PORT_DIV - 1);
            if (--sysLeft == 0) begin
              sysSeg++; sysBlankN = ~sysBlankN;
              sysLeft = 6 + ((sysSeg * 37 + cfg * 11) % 45);
            end
            if (--portLeft == 0) begin
              portSeg++; portBlankN = ~portBlankN;
              portLeft = 4 + ((portSeg * 23 + cfg * 7) % 50);
            end
            @(negedge clk);
          end
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule